// File: doc/BRIEF.md
# Cascaded BCD Time-of-Day Counter

This block keeps a 24-hour time of day as six binary-coded decimal digits. The digits are seconds, minutes and hours, each split into units and tens. A prescaler divides the system clock, whose frequency is a parameter, down to a one-cycle enable once per second. That enable steps the seconds-units digit. Each digit then hands a carry to the digit above it in the same clock cycle that it wraps, so the digits can never disagree about the time.

A set input shortens the prescaler period by a fixed factor, 2000 by default. Holding it lets a user run the clock forward quickly to the wanted time. Everything runs on the one clock. No digit value is ever used as a clock; the carries are enables.

Top module: `tod_counter`

## Requirements
- R1: While `rst_n` is low, all six digit outputs read 0 on the following clock edge, and the prescaler restarts from zero. After release, the first step comes CLK_HZ cycles later.
- R2: With `set_fast` low, the time advances by exactly one second every CLK_HZ clock cycles.
- R3: With `set_fast` high, the time advances by one second every CLK_HZ/FAST_FACTOR clock cycles, and at least every cycle. If the prescaler count already reaches the shorter period when the mode changes, the step is taken on that cycle.
- R4: Every digit stays within its range. Units digits hold 0..9. Seconds and minutes tens hold 0..5. Hours tens holds 0..2. Hours units holds 0..3 while hours tens is 2.
- R5: On a step, a units digit at 9 returns to 0 and the tens digit of the same field increments on the same clock edge.
- R6: A step at ss = 59 gives ss = 00 and increments the minutes on the same edge.
- R7: A step at mm:ss = 59:59 gives 00:00 and increments the hours on the same edge. This includes 09 going to 10 and 19 going to 20.
- R8: A step at 23:59:59 gives 00:00:00, in either speed mode.
- R9: No digit changes on a cycle without a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ hertz |
| rst_n | input | 1 | Synchronous active-low reset |
| set_fast | input | 1 | High selects the fast setting rate |
| sec_ones | output | 4 | Seconds units, BCD |
| sec_tens | output | 4 | Seconds tens, BCD |
| min_ones | output | 4 | Minutes units, BCD |
| min_tens | output | 4 | Minutes tens, BCD |
| hour_ones | output | 4 | Hours units, BCD |
| hour_tens | output | 4 | Hours tens, BCD |

## Verification
The assertions check on every cycle that each digit stays in range and that the digits hold still between steps. They also check that a units digit at 9 comes back to 0 when it steps, that the day wraps to all zeros, and that reset clears the outputs. The step period in each mode cannot be seen from a single cycle, so the bench shows it instead. It runs a behavioural seconds-of-day model alongside the design and compares on every clock. The model covers normal speed, a full day plus an extra wrap in set mode, switches between the modes, and a reset in the middle of a run.

// File: rtl/tod_pkg.sv
// Package: tod_pkg
// Shared digit type, digit slot numbering and fixed wrap limits for the
// time-of-day counter. Assumes BCD digits of four bits.
package tod_pkg;

    localparam int DIGIT_W   = 4;
    localparam int NUM_DIGIT = 6;

    typedef logic [DIGIT_W-1:0] bcd_t;

    // Slot order is the carry order: slot i feeds the enable of slot i+1.
    localparam int SLOT_SEC_ONES  = 0;
    localparam int SLOT_SEC_TENS  = 1;
    localparam int SLOT_MIN_ONES  = 2;
    localparam int SLOT_MIN_TENS  = 3;
    localparam int SLOT_HOUR_ONES = 4;
    localparam int SLOT_HOUR_TENS = 5;

    localparam bcd_t LIM_UNITS      = 4'd9;
    localparam bcd_t LIM_SIXTY_TENS = 4'd5;
    localparam bcd_t LIM_HOUR_TENS  = 4'd2;
    localparam bcd_t LIM_HOUR_LATE  = 4'd3;

    // Fixed terminal value for a slot; the hours-units slot is resolved at run time.
    function automatic bcd_t fixed_limit(input int slot);
        case (slot)
            SLOT_SEC_TENS, SLOT_MIN_TENS: fixed_limit = LIM_SIXTY_TENS;
            SLOT_HOUR_TENS:               fixed_limit = LIM_HOUR_TENS;
            default:                      fixed_limit = LIM_UNITS;
        endcase
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
// Module: tod_prescaler
// Divides the system clock into a one-cycle step enable. The slow period is
// CLK_HZ cycles. The fast period is CLK_HZ/FAST_FACTOR cycles, clamped to
// at least one. Assumes CLK_HZ >= 1. A count at or past the active period's
// terminal value fires at once, so a switch to fast mode never stalls.
module tod_prescaler #(
    parameter int CLK_HZ      = 100_000_000,
    parameter int FAST_FACTOR = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic step
);
    localparam int SLOW_DIV = (CLK_HZ < 1) ? 1 : CLK_HZ;
    localparam int FAST_RAW = CLK_HZ / ((FAST_FACTOR < 1) ? 1 : FAST_FACTOR);
    localparam int FAST_DIV = (FAST_RAW < 1) ? 1 : FAST_RAW;
    localparam int CNT_W    = (SLOW_DIV < 2) ? 1 : $clog2(SLOW_DIV);

    localparam logic [CNT_W-1:0] SLOW_TERM = CNT_W'(SLOW_DIV - 1);
    localparam logic [CNT_W-1:0] FAST_TERM = CNT_W'(FAST_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;

    // Pick the terminal count of the active mode.
    always_comb term = fast ? FAST_TERM : SLOW_TERM;

    // Fire when the count has reached the terminal value.
    always_comb step = (cnt_q >= term);

    // Advance the count; restart after each step or on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (step)  cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/tod_digit.sv
// Module: tod_digit
// One BCD digit stage. When en is high it increments, or it returns to zero
// if its value equals limit. carry_out flags that wrap on the same cycle, so
// the next stage steps on the same edge. Assumes limit <= 9 and a value that
// never lies above limit (hours-units is re-limited only at 2x, where it is <= 3).
module tod_digit
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  bcd_t limit,
    output bcd_t value,
    output logic carry_out
);
    logic at_term;

    // Terminal decode on the registered value.
    always_comb at_term = (value == limit);

    // Carry is a same-cycle enable for the next stage, never a clock.
    always_comb carry_out = en && at_term;

    // Digit register: clear, wrap or increment on enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       value <= '0;
        else if (en) begin
            if (at_term)  value <= '0;
            else          value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/tod_counter.sv
// Module: tod_counter (top)
// 24-hour BCD time-of-day counter: a prescaler feeding a chain of six digit
// stages. The hours-units limit depends on the hours-tens digit so that
// 23:59:59 wraps to 00:00:00. Assumes a single clock domain and a
// synchronous active-low reset.
module tod_counter
    import tod_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int FAST_FACTOR = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_fast,
    output logic [3:0] sec_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] min_ones,
    output logic [3:0] min_tens,
    output logic [3:0] hour_ones,
    output logic [3:0] hour_tens
);
    logic                 tick;
    logic [NUM_DIGIT:0]   chain_en;
    bcd_t [NUM_DIGIT-1:0] dig;
    bcd_t [NUM_DIGIT-1:0] lim;

    tod_prescaler #(
        .CLK_HZ      (CLK_HZ),
        .FAST_FACTOR (FAST_FACTOR)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .fast  (set_fast),
        .step  (tick)
    );

    // Seconds-units stage is enabled by the prescaler step.
    always_comb chain_en[0] = tick;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_DIGIT; gi++) begin : g_stage
            if (gi == SLOT_HOUR_ONES) begin : g_dyn
                // Hours units: wrap after 3 in the twenties, else after 9.
                always_comb lim[gi] = (dig[SLOT_HOUR_TENS] == LIM_HOUR_TENS)
                                      ? LIM_HOUR_LATE : LIM_UNITS;
            end else begin : g_fix
                // Fixed wrap limit for this slot.
                always_comb lim[gi] = fixed_limit(gi);
            end

            tod_digit u_dig (
                .clk       (clk),
                .rst_n     (rst_n),
                .en        (chain_en[gi]),
                .limit     (lim[gi]),
                .value     (dig[gi]),
                .carry_out (chain_en[gi+1])
            );
        end
    endgenerate

    // Map slots to the output ports.
    always_comb begin
        sec_ones  = dig[SLOT_SEC_ONES];
        sec_tens  = dig[SLOT_SEC_TENS];
        min_ones  = dig[SLOT_MIN_ONES];
        min_tens  = dig[SLOT_MIN_TENS];
        hour_ones = dig[SLOT_HOUR_ONES];
        hour_tens = dig[SLOT_HOUR_TENS];
    end

endmodule

// File: rtl/tod_counter_chk.sv
// Module: tod_counter_chk
// Property checker bound to tod_counter. It watches the output digits and
// the internal step enable.
module tod_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [3:0] s1,
    input logic [3:0] s10,
    input logic [3:0] m1,
    input logic [3:0] m10,
    input logic [3:0] h1,
    input logic [3:0] h10
);
    logic [23:0] all_d;
    always_comb all_d = {h10, h1, m10, m1, s10, s1};

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (all_d == 24'h0));

    assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1 <= 4'd9) && (m1 <= 4'd9) && (h1 <= 4'd9) &&
        (s10 <= 4'd5) && (m10 <= 4'd5) && (h10 <= 4'd2) &&
        ((h10 != 4'd2) || (h1 <= 4'd3)));

    assert_units_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s1 == 4'd9) |=> (s1 == 4'd0));

    assert_day_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && all_d == 24'h235959) |=> (all_d == 24'h0));

    assert_hold_no_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(all_d));

endmodule

bind tod_counter tod_counter_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .s1    (sec_ones),
    .s10   (sec_tens),
    .m1    (min_ones),
    .m10   (min_tens),
    .h1    (hour_ones),
    .h10   (hour_tens)
);

// File: tb/sim_tod_counter.sv
// Bench: behavioural seconds-of-day model compared with the design every clock.
module sim_tod_counter;
    localparam int HZ   = 2000;
    localparam int FAST = 2000;
    localparam int SLOW_P = HZ;
    localparam int FAST_P = (HZ / FAST < 1) ? 1 : HZ / FAST;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_fast = 1'b0;
    logic [3:0] so, st, mo, mt, ho, ht;

    int n_chk = 0;
    int n_bad = 0;
    int m_cnt = 0;
    int m_secs = 0;
    int prev_secs = 0;
    bit m_step = 0;
    bit in_rst = 1;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    tod_counter #(.CLK_HZ(HZ), .FAST_FACTOR(FAST)) u0 (
        .clk(clk), .rst_n(rst_n), .set_fast(set_fast),
        .sec_ones(so), .sec_tens(st), .min_ones(mo),
        .min_tens(mt), .hour_ones(ho), .hour_tens(ht)
    );

    // Reference model: prescaler count and seconds since midnight.
    always @(posedge clk) begin
        prev_secs = m_secs;
        if (!rst_n) begin
            m_cnt = 0; m_secs = 0; m_step = 0; in_rst = 1;
        end else begin
            int per;
            in_rst = 0;
            per = set_fast ? FAST_P : SLOW_P;
            m_step = (m_cnt >= per - 1);
            m_cnt = m_step ? 0 : m_cnt + 1;
            if (m_step) m_secs = (m_secs + 1) % 86400;
        end
    end

    function automatic logic [23:0] to_bcd(input int s);
        int h, m, x;
        h = s / 3600; m = (s / 60) % 60; x = s % 60;
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(x / 10), 4'(x % 10)};
    endfunction

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare away from the active edge, tagging by what the last step did.
    always @(negedge clk) begin
        if (!done) begin
            logic [23:0] act;
            string tag;
            act = {ht, ho, mt, mo, st, so};
            if (in_rst)                                         tag = "R1";
            else if (!m_step)                                   tag = "R9";
            else if (m_secs == 0)                               tag = "R8";
            else if (m_secs % 3600 == 0)                        tag = "R7";
            else if (m_secs % 60 == 0)                          tag = "R6";
            else if (m_secs % 10 == 0)                          tag = "R5";
            else if (set_fast)                                  tag = "R3";
            else                                                tag = "R2";
            check(tag, act, to_bcd(m_secs));
            if (!in_rst) begin
                // R4: hours never exceed 23 and fields never exceed 59
                n_chk++;
                if (st > 4'd5 || mt > 4'd5 || {ht, ho} > 8'h23 || so > 4'd9 || mo > 4'd9 || ho > 4'd9) begin
                    n_bad++;
                    $display("FAIL R4: actual %h expected in range", act);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stimulus.
    initial begin
        wait_cyc(4);
        rst_n = 1'b1;                 // R1 then R2: first step after HZ cycles
        wait_cyc(5 * SLOW_P + 7);
        set_fast = 1'b1;              // R3: full day plus one extra wrap (R8)
        wait_cyc(86400 * FAST_P + 200);
        set_fast = 1'b0;              // back to R2 speed
        wait_cyc(3 * SLOW_P + 3);
        set_fast = 1'b1;
        wait_cyc(1000);
        rst_n = 1'b0;                 // R1 mid-run reset
        wait_cyc(3);
        rst_n = 1'b1;
        set_fast = 1'b0;
        wait_cyc(2 * SLOW_P + 5);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule